// File: doc/BRIEF.md
# Post-Increment Load Executor

This block carries out a single register-indirect load with pointer advance, one stage per clock. On a start pulse it reads a two-byte instruction from a byte-wide instruction port at its own program counter and checks the encoding. It reads the pointer register from an external register file and adds four to it. It then reads a little-endian word from the data port at the original pointer. The pointer register receives the sum and the destination register receives the loaded word. The program counter then moves past the instruction and a one-cycle completion pulse is raised.

Any encoding other than the one load is reported through a status output. In that case no register is written and the program counter keeps its value. A parameter selects whether the data port returns a whole word in one beat or one byte per beat.

Top module: `postinc_load_unit`

## Requirements
- R1: After reset, `done` and `bad_instr` are 0, `rf_we` is 0 and `pc_o` equals `RESET_PC` (0 by default).
- R2: The instruction is the byte at `pc_o` followed by the byte at `pc_o`+1. The first byte must be 0x5F. In the second byte, bits [7:4] name the destination register rA and bits [3:0] name the pointer register rB.
- R3: The pointer register rB is written with its old value plus 4, modulo 2^32.
- R4: The data read uses the unmodified rB value as its address. In byte mode the word is assembled little-endian from the bytes at addresses rB, rB+1, rB+2 and rB+3, each address computed modulo 2^32.
- R5: rA receives the loaded word. The rB write always comes first and the rA write second, so when rA equals rB the loaded word is the final value.
- R6: After a legal instruction, `pc_o` has advanced by exactly 2.
- R7: A first byte other than 0x5F sets `bad_instr` together with `done`. No register is written and `pc_o` is unchanged.
- R8: A register code of `NREGS` or above in either nibble is illegal in the same way as R7. This includes code F, which means no register.
- R9: `done` is high for exactly one cycle. It is first visible 8+BEATS cycles after the clock edge that samples `start` for a legal instruction, and 4 cycles after it for an illegal one. BEATS is 4 in byte mode and 1 in word mode.
- R10: A `start` pulse while an instruction is in progress is ignored. It produces neither an extra register write nor an extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one instruction when idle |
| done | output | 1 | One-cycle completion pulse |
| bad_instr | output | 1 | Last instruction was illegal; held until next start |
| pc_o | output | PC_W | Current program counter |
| imem_addr | output | PC_W | Instruction byte address |
| imem_data | input | 8 | Instruction byte at `imem_addr` |
| dmem_addr | output | XLEN | Data address |
| dmem_re | output | 1 | Data read strobe |
| dmem_data | input | XLEN | Data returned at `dmem_addr` (low byte only in byte mode) |
| rf_raddr | output | RIDX_W | Register file read index |
| rf_rdata | input | XLEN | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | RIDX_W | Register file write index |
| rf_wdata | output | XLEN | Register file write data |

## Verification
The bench builds the unit with `BYTE_DMEM=1`, 32-bit data and eight registers. This exercises the four-beat little-endian assembly and the address wrap across zero. It also fixes the 12-cycle legal latency. With eight registers, codes 8 through F fall in the illegal range, so an out-of-range index can be tested alongside the reserved code F.

// File: rtl/pli_pkg.sv
package pli_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FETCH0,
      ST_FETCH1,
      ST_DECODE,
      ST_EXEC,
      ST_MEM,
      ST_WB_PTR,
      ST_WB_DST,
      ST_PC,
      ST_DONE
   } pli_state_e;
endpackage

// File: rtl/pli_decoder.sv
module pli_decoder #(
   parameter int NREGS = 8,
   parameter logic [7:0] OP_BYTE = 8'h5F
) (
   input  logic [7:0] op_byte,
   input  logic [7:0] reg_byte,
   output logic [3:0] ra_code,
   output logic [3:0] rb_code,
   output logic       legal
);
   localparam logic [4:0] LIMIT = 5'(NREGS);
   logic ra_ok, rb_ok;
   always_comb begin
      ra_code = reg_byte[7:4];
      rb_code = reg_byte[3:0];
      ra_ok   = {1'b0, ra_code} < LIMIT;
      rb_ok   = {1'b0, rb_code} < LIMIT;
      legal   = (op_byte == OP_BYTE) && ra_ok && rb_ok;
   end
endmodule

// File: rtl/pli_gather.sv
module pli_gather #(
   parameter int XLEN      = 32,
   parameter bit BYTE_DMEM = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            beat_en,
   input  logic [XLEN-1:0] rdata,
   output logic [XLEN-1:0] word,
   output logic [XLEN-1:0] offset,
   output logic            last
);
   localparam int BEATS = BYTE_DMEM ? XLEN / 8 : 1;
   localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

   generate
      if (BYTE_DMEM) begin : g_byte
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               word <= '0;
            end else if (clear) begin
               cnt <= '0;
            end else if (beat_en) begin
               cnt  <= cnt + 1'b1;
               word <= {rdata[7:0], word[XLEN-1:8]};
            end
         end
         assign offset = XLEN'(cnt);
         assign last   = (cnt == CNT_W'(BEATS - 1));
      end else begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word <= '0;
            else if (beat_en) word <= rdata;
         end
         assign offset = '0;
         assign last   = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/pli_ctrl.sv
module pli_ctrl
   import pli_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       legal,
   input  logic       last_beat,
   output pli_state_e state
);
   pli_state_e nxt;
   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:   if (start) nxt = ST_FETCH0;
         ST_FETCH0: nxt = ST_FETCH1;
         ST_FETCH1: nxt = ST_DECODE;
         ST_DECODE: nxt = legal ? ST_EXEC : ST_DONE;
         ST_EXEC:   nxt = ST_MEM;
         ST_MEM:    if (last_beat) nxt = ST_WB_PTR;
         ST_WB_PTR: nxt = ST_WB_DST;
         ST_WB_DST: nxt = ST_PC;
         ST_PC:     nxt = ST_DONE;
         ST_DONE:   nxt = ST_IDLE;
         default:   nxt = ST_IDLE;
      endcase
   end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/postinc_load_unit.sv
module postinc_load_unit
   import pli_pkg::*;
#(
   parameter int          XLEN      = 32,
   parameter int          PC_W      = 32,
   parameter int          NREGS     = 8,
   parameter bit          BYTE_DMEM = 1'b0,
   parameter logic [31:0] RESET_PC  = 32'h0,
   parameter int          PTR_STEP  = 4,
   parameter int          INSN_LEN  = 2,
   localparam int         RIDX_W    = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              done,
   output logic              bad_instr,
   output logic [PC_W-1:0]   pc_o,
   output logic [PC_W-1:0]   imem_addr,
   input  logic [7:0]        imem_data,
   output logic [XLEN-1:0]   dmem_addr,
   output logic              dmem_re,
   input  logic [XLEN-1:0]   dmem_data,
   output logic [RIDX_W-1:0] rf_raddr,
   input  logic [XLEN-1:0]   rf_rdata,
   output logic              rf_we,
   output logic [RIDX_W-1:0] rf_waddr,
   output logic [XLEN-1:0]   rf_wdata
);
   generate
      if (NREGS < 2 || NREGS > 15) begin : g_bad_nregs
         $error("NREGS must lie in 2..15; code F is reserved");
      end
      if (XLEN < 8 || (XLEN % 8) != 0) begin : g_bad_xlen
         $error("XLEN must be a whole number of bytes");
      end
      if (PC_W < 2) begin : g_bad_pcw
         $error("PC_W too narrow");
      end
   endgenerate

   pli_state_e        state;
   logic [PC_W-1:0]   pc_q;
   logic [7:0]        op_q, regs_q;
   logic [XLEN-1:0]   ptr_q, sum_q, word, offset;
   logic [3:0]        ra_code, rb_code;
   logic              legal, last_beat, bad_q;

   pli_decoder #(.NREGS(NREGS), .OP_BYTE(8'h5F)) u_dec (
      .op_byte (op_q),
      .reg_byte(regs_q),
      .ra_code (ra_code),
      .rb_code (rb_code),
      .legal   (legal)
   );

   pli_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .legal    (legal),
      .last_beat(last_beat),
      .state    (state)
   );

   pli_gather #(.XLEN(XLEN), .BYTE_DMEM(BYTE_DMEM)) u_gather (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (state == ST_EXEC),
      .beat_en(state == ST_MEM),
      .rdata  (dmem_data),
      .word   (word),
      .offset (offset),
      .last   (last_beat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= PC_W'(RESET_PC);
         op_q   <= '0;
         regs_q <= '0;
         ptr_q  <= '0;
         sum_q  <= '0;
         bad_q  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE:   if (start) bad_q <= 1'b0;
            ST_FETCH0: op_q   <= imem_data;
            ST_FETCH1: regs_q <= imem_data;
            ST_DECODE: begin
               ptr_q <= rf_rdata;
               if (!legal) bad_q <= 1'b1;
            end
            ST_EXEC:   sum_q <= ptr_q + XLEN'(PTR_STEP);
            ST_PC:     pc_q  <= pc_q + PC_W'(INSN_LEN);
            default: ;
         endcase
      end
   end

   assign imem_addr = (state == ST_FETCH1) ? pc_q + PC_W'(1) : pc_q;
   assign pc_o      = pc_q;
   assign done      = (state == ST_DONE);
   assign bad_instr = bad_q;
   assign dmem_re   = (state == ST_MEM);
   assign dmem_addr = ptr_q + offset;
   assign rf_raddr  = rb_code[RIDX_W-1:0];
   assign rf_we     = (state == ST_WB_PTR) || (state == ST_WB_DST);
   assign rf_waddr  = (state == ST_WB_PTR) ? rb_code[RIDX_W-1:0] : ra_code[RIDX_W-1:0];
   assign rf_wdata  = (state == ST_WB_PTR) ? sum_q : word;
endmodule

// File: rtl/pli_checker.sv
module pli_checker #(
   parameter int PC_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            done,
   input logic            bad_instr,
   input logic            rf_we,
   input logic [PC_W-1:0] pc_o
);
   // R9: completion is a single-cycle pulse
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: no register write happens while the illegal status is raised
   assert_no_write_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> !bad_instr);
   // R6: the program counter only ever moves forward by two
   assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_o != $past(pc_o)) |-> (pc_o == $past(pc_o) + PC_W'(2)));
   // R8: illegal status appears together with completion
   assert_bad_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bad_instr) |-> done);
   // R7: an illegal completion leaves the program counter as it was
   assert_bad_pc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && bad_instr) |-> $stable(pc_o));
   // R5: the two writes of one instruction are never followed by a third
   assert_two_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && $past(rf_we)) |=> !rf_we);
endmodule

bind postinc_load_unit pli_checker #(.PC_W(PC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .done     (done),
   .bad_instr(bad_instr),
   .rf_we    (rf_we),
   .pc_o     (pc_o)
);

// File: tb/sim_postinc_load_unit.sv
`timescale 1ns/1ps
module sim_postinc_load_unit;
   localparam int XLEN = 32;
   localparam int PC_W = 32;
   localparam int NREGS = 8;
   localparam int RIDX_W = $clog2(NREGS);
   localparam int BEATS = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic done, bad_instr, dmem_re, rf_we;
   logic [PC_W-1:0] pc_o, imem_addr;
   logic [XLEN-1:0] dmem_addr, dmem_data, rf_rdata, rf_wdata;
   logic [RIDX_W-1:0] rf_raddr, rf_waddr;
   logic [7:0] imem_data;

   logic [7:0]      imem [64];
   logic [7:0]      dmem [256];
   logic [XLEN-1:0] regs [NREGS];

   int checks = 0;
   int fails = 0;
   logic [PC_W-1:0] exp_pc = '0;

   typedef struct packed {
      logic [RIDX_W-1:0] idx;
      logic [XLEN-1:0]   val;
      logic [7:0]        tag;
   } wr_item_t;
   wr_item_t exp_q[$];

   always #5 clk = ~clk;

   postinc_load_unit #(.XLEN(XLEN), .PC_W(PC_W), .NREGS(NREGS), .BYTE_DMEM(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done), .bad_instr(bad_instr),
      .pc_o(pc_o), .imem_addr(imem_addr), .imem_data(imem_data),
      .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_data(dmem_data),
      .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
      .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
   );

   assign imem_data = imem[imem_addr[5:0]];
   assign dmem_data = {24'h0, dmem[dmem_addr[7:0]]};
   assign rf_rdata  = regs[rf_raddr];

   always @(posedge clk) if (rf_we) regs[rf_waddr] <= rf_wdata;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: every register write is matched against the scoreboard
   always @(negedge clk) begin
      if (rst_n && rf_we) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7/R10 unexpected write", {32'h0, rf_wdata}, 64'h0);
         end else begin
            wr_item_t e;
            e = exp_q.pop_front();
            check(rf_waddr == e.idx && rf_wdata == e.val,
                  (e.tag == 8'd3) ? "R3 pointer write" : "R4/R5 loaded write",
                  {29'h0, rf_waddr, rf_wdata}, {29'h0, e.idx, e.val});
         end
      end
   end

   task automatic run_instr(input logic [7:0] b0, input logic [7:0] b1, input bit poke);
      bit legal;
      logic [3:0] ra, rb;
      logic [XLEN-1:0] ptr, w;
      int lat, ndone, first;
      ra = b1[7:4];
      rb = b1[3:0];
      legal = (b0 == 8'h5F) && (ra < NREGS) && (rb < NREGS);
      imem[exp_pc[5:0]]        = b0;
      imem[exp_pc[5:0] + 6'd1] = b1;
      if (legal) begin
         ptr = regs[rb[RIDX_W-1:0]];
         for (int i = 0; i < BEATS; i++) begin
            logic [XLEN-1:0] a;
            a = ptr + XLEN'(i);
            w[8*i +: 8] = dmem[a[7:0]];
         end
         exp_q.push_back('{idx: rb[RIDX_W-1:0], val: ptr + 32'd4, tag: 8'd3});
         exp_q.push_back('{idx: ra[RIDX_W-1:0], val: w, tag: 8'd5});
      end
      lat = legal ? 8 + BEATS : 4;
      ndone = 0;
      first = 0;
      start = 1'b1;
      for (int n = 1; n <= lat + 16; n++) begin
         @(negedge clk);
         if (n == 1) start = 1'b0;
         if (poke && n == 5) start = 1'b1;
         if (poke && n == 6) start = 1'b0;
         if (done) begin
            ndone++;
            if (first == 0) begin
               first = n;
               check(bad_instr == !legal, legal ? "R2 legal status" : "R7/R8 illegal status",
                     {63'h0, bad_instr}, {63'h0, !legal});
            end
         end
      end
      check(first == lat, "R9 latency", first, lat);
      check(ndone == 1, poke ? "R10 single done" : "R9 single done", ndone, 1);
      if (legal) exp_pc = exp_pc + 2;
      check(pc_o == exp_pc, legal ? "R6 pc advance" : "R7 pc hold", pc_o, exp_pc);
      check(exp_q.size() == 0, "R5 writes complete", exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin
      for (int i = 0; i < 64; i++) imem[i] = 8'h00;
      for (int i = 0; i < 256; i++) dmem[i] = 8'(i * 7 + 3);
      for (int i = 0; i < NREGS; i++) regs[i] = 32'(i * 16);
      dmem[8'h10] = 8'h44; dmem[8'h11] = 8'h33; dmem[8'h12] = 8'h22; dmem[8'h13] = 8'h11;
      regs[2] = 32'h10;
      regs[4] = 32'hFFFF_FFFE;
      regs[5] = 32'h40;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(done == 1'b0, "R1 done", done, 0);
      check(bad_instr == 1'b0, "R1 status", bad_instr, 0);
      check(pc_o == 0, "R1 pc", pc_o, 0);
      check(rf_we == 1'b0, "R1 write", rf_we, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run_instr(8'h5F, 8'h12, 1'b0);   // R2 R3 R4: r1 <- m[0x10], r2 += 4
      check(regs[1] == 32'h11223344, "R4 little-endian word", regs[1], 32'h11223344);
      check(regs[2] == 32'h14, "R3 pointer sum", regs[2], 32'h14);
      run_instr(8'h5F, 8'h32, 1'b0);   // reads at 0x14 with new pointer
      run_instr(8'h5F, 8'h55, 1'b0);   // R5: same register, loaded word wins
      check(regs[5] == {dmem[8'h43], dmem[8'h42], dmem[8'h41], dmem[8'h40]},
            "R5 same-register final value", regs[5],
            {dmem[8'h43], dmem[8'h42], dmem[8'h41], dmem[8'h40]});
      run_instr(8'h5F, 8'h64, 1'b0);   // R3 R4 wrap across zero
      check(regs[4] == 32'h2, "R3 wrap", regs[4], 32'h2);
      run_instr(8'h50, 8'h12, 1'b0);   // R7 bad function nibble
      run_instr(8'h4F, 8'h12, 1'b0);   // R7 bad opcode nibble
      run_instr(8'h5F, 8'hF1, 1'b0);   // R8 rA code F
      run_instr(8'h5F, 8'h18, 1'b0);   // R8 rB out of range
      run_instr(8'h5F, 8'h07, 1'b1);   // R10 start while busy
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #2000000;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule